// File: doc/BRIEF.md
# Scoreboarded Warp Issue Scheduler

This block is the instruction issue stage of one multithreaded processor core. It holds one buffered instruction for each warp and asks an instruction fetch unit to refill any warp whose buffer is empty, one request per cycle. Each cycle it considers every buffered instruction, keeps those whose register operands are not waiting on a long-latency result, and sends at most one of them to the execution lanes together with its warp number. The same instruction then runs on all threads of that warp.

A scoreboard holds one pending bit for each register of each warp. Issuing an instruction flagged as long-latency sets the bit of its destination register. A writeback event that names a warp and a register clears that bit. Warps are chosen by round-robin: the search starts at the warp just after the one that last issued. Because a warp has more threads than there are lanes, one issued warp instruction occupies the lanes for several cycles, and no other issue can happen in that time.

Instruction word fields, with REG_W = log2(NUM_REGS): bits [REG_W-1:0] first source register, [2*REG_W-1:REG_W] second source register, [3*REG_W-1:2*REG_W] destination register, bit [3*REG_W] long-latency flag. The remaining upper bits are an opaque payload. With the defaults (16 registers, 20-bit word) these are [3:0], [7:4], [11:8], [12] and [19:13].

Top module: `wis_issue_sched`

## Requirements
- R1: After reset no issue is presented, every instruction slot is empty, every scoreboard bit is clear, and the fetch request names warp 0.
- R2: The fetch request is valid whenever some warp has an empty slot and no outstanding request. It names the lowest such warp. A request counts as outstanding from the cycle fetch_req_ready is high until that warp's slot is filled.
- R3: A fill response writes the instruction into the named warp's slot only if that slot was empty at the start of the cycle. A fill to a full slot is ignored, and the instruction already held is issued later unchanged.
- R4: A buffered instruction is eligible only if neither of its source registers (bits [3:0] and [7:4]) is pending in its own warp's scoreboard.
- R5: A buffered instruction whose destination register (bits [11:8]) is pending in its warp is held back, so that a write-after-write hazard cannot occur.
- R6: At most one instruction is issued per cycle. After an issue decision, the next decision is made no sooner than WARP_THREADS/EXEC_LANES (4) cycles later.
- R7: The search starts at the warp after the last issued warp and wraps around. A stalled warp never prevents an eligible warp from issuing while the lanes are free.
- R8: Issuing an instruction with bit [12] set marks its destination register pending in its warp. A writeback naming a warp and a register clears that mark. A writeback to a register that is not pending has no effect.
- R9: issue_valid is high for the single cycle after an issue decision. It carries that warp's number and its buffered instruction unchanged, and the warp's slot is empty from then on.
- R10: In a cycle with no eligible warp, or with the lanes still busy, issue_valid is low and the slots, the scoreboard and the round-robin position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req_valid | output | 1 | A warp needs an instruction fetched |
| fetch_req_ready | input | 1 | The fetch unit accepts the request this cycle |
| fetch_req_warp | output | WID_W | Warp the request is for |
| fill_valid | input | 1 | A fetched instruction is delivered |
| fill_warp | input | WID_W | Warp the delivered instruction belongs to |
| fill_instr | input | INSTR_W | Delivered instruction word |
| wb_valid | input | 1 | A long-latency result has been written back |
| wb_warp | input | WID_W | Warp of the written-back register |
| wb_reg | input | REG_W | Register that was written back |
| issue_valid | output | 1 | An instruction is sent to the lanes |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_instr | output | INSTR_W | Issued instruction word |

## Verification
The bench builds the scheduler with 5 warps instead of 24. The round-robin pointer therefore wraps every few issues, and every slot is refilled and reissued many times within a short run. The default of 16 registers and 4-cycle lane occupancy is kept, so operand, destination and writeback collisions in the scoreboard happen often under random register choices. A phase with frequent writebacks is followed by a phase with rare writebacks, which keeps most warps stalled and exercises the no-eligible and skip-over-stalled cases.

// File: rtl/wis_pkg.sv
package wis_pkg;
   localparam int DEF_NUM_WARPS    = 24;
   localparam int DEF_NUM_REGS     = 16;
   localparam int DEF_INSTR_W      = 20;
   localparam int DEF_WARP_THREADS = 32;
   localparam int DEF_EXEC_LANES   = 8;

   // cycles one warp instruction keeps the lanes busy
   function automatic int lane_cycles(input int threads, input int lanes);
      return (threads + lanes - 1) / lanes;
   endfunction
endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
   parameter int NUM_WARPS = 24,
   parameter int NUM_REGS  = 16,
   localparam int WID_W    = $clog2(NUM_WARPS),
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 set_en,
   input  logic [WID_W-1:0]                     set_warp,
   input  logic [REG_W-1:0]                     set_reg,
   input  logic                                 clr_en,
   input  logic [WID_W-1:0]                     clr_warp,
   input  logic [REG_W-1:0]                     clr_reg,
   output logic [NUM_WARPS-1:0][NUM_REGS-1:0]   pend
);
   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      logic hit_set, hit_clr;
      assign hit_set = set_en && (set_warp == WID_W'(w));
      assign hit_clr = clr_en && (clr_warp == WID_W'(w));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[w] <= '0;
         end else begin
            for (int r = 0; r < NUM_REGS; r++) begin
               if (hit_set && set_reg == REG_W'(r))
                  pend[w][r] <= 1'b1;
               else if (hit_clr && clr_reg == REG_W'(r))
                  pend[w][r] <= 1'b0;
            end
         end
      end
   end

   // R8: a set lands in the named warp and register
   assert_set_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend[$past(set_warp)][$past(set_reg)]);
   // R8: a writeback clears unless the same bit is being set
   assert_wb_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && !(set_en && set_warp == clr_warp && set_reg == clr_reg)
      |=> !pend[$past(clr_warp)][$past(clr_reg)]);
endmodule

// File: rtl/wis_instr_buf.sv
module wis_instr_buf #(
   parameter int NUM_WARPS = 24,
   parameter int INSTR_W   = 20,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                fill_valid,
   input  logic [WID_W-1:0]                    fill_warp,
   input  logic [INSTR_W-1:0]                  fill_instr,
   input  logic                                req_ready,
   output logic                                req_valid,
   output logic [WID_W-1:0]                    req_warp,
   input  logic                                take_en,
   input  logic [WID_W-1:0]                    take_warp,
   output logic [NUM_WARPS-1:0]                slot_valid,
   output logic [NUM_WARPS-1:0][INSTR_W-1:0]   slot_instr
);
   logic [NUM_WARPS-1:0] outstanding;

   always_comb begin
      req_valid = 1'b0;
      req_warp  = '0;
      for (int w = 0; w < NUM_WARPS; w++) begin
         if (!req_valid && !slot_valid[w] && !outstanding[w]) begin
            req_valid = 1'b1;
            req_warp  = WID_W'(w);
         end
      end
   end

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      logic do_fill, do_take, do_req;
      assign do_fill = fill_valid && fill_warp == WID_W'(w) && !slot_valid[w];
      assign do_take = take_en && take_warp == WID_W'(w);
      assign do_req  = req_valid && req_ready && req_warp == WID_W'(w);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[w]  <= 1'b0;
            slot_instr[w]  <= '0;
            outstanding[w] <= 1'b0;
         end else begin
            if (do_take) slot_valid[w] <= 1'b0;
            if (do_fill) begin
               slot_valid[w]  <= 1'b1;
               slot_instr[w]  <= fill_instr;
               outstanding[w] <= 1'b0;
            end else if (do_req) begin
               outstanding[w] <= 1'b1;
            end
         end
      end
   end

   // R3: a fill aimed at a full slot leaves the held word untouched
   assert_fill_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && slot_valid[fill_warp]
      |=> slot_instr[$past(fill_warp)] == $past(slot_instr[fill_warp]));
   // R2: a request never names a warp whose slot is full
   assert_req_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !slot_valid[req_warp]);
endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
   parameter int NUM_WARPS = 24,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_WARPS-1:0]  req,
   input  logic [WID_W-1:0]      start,
   output logic                  gnt_valid,
   output logic [WID_W-1:0]      gnt_idx
);
   always_comb begin
      gnt_valid = 1'b0;
      gnt_idx   = '0;
      for (int i = 0; i < NUM_WARPS; i++) begin
         int k;
         k = int'(start) + i;
         if (k >= NUM_WARPS) k = k - NUM_WARPS;
         if (!gnt_valid && req[k]) begin
            gnt_valid = 1'b1;
            gnt_idx   = WID_W'(k);
         end
      end
   end

   // R7: any eligible warp yields a grant, and the grant is eligible
   assert_no_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> gnt_valid);
   assert_grant_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched #(
   parameter int NUM_WARPS    = wis_pkg::DEF_NUM_WARPS,
   parameter int NUM_REGS     = wis_pkg::DEF_NUM_REGS,
   parameter int INSTR_W      = wis_pkg::DEF_INSTR_W,
   parameter int WARP_THREADS = wis_pkg::DEF_WARP_THREADS,
   parameter int EXEC_LANES   = wis_pkg::DEF_EXEC_LANES,
   localparam int WID_W       = $clog2(NUM_WARPS),
   localparam int REG_W       = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                fetch_req_valid,
   input  logic                fetch_req_ready,
   output logic [WID_W-1:0]    fetch_req_warp,
   input  logic                fill_valid,
   input  logic [WID_W-1:0]    fill_warp,
   input  logic [INSTR_W-1:0]  fill_instr,
   input  logic                wb_valid,
   input  logic [WID_W-1:0]    wb_warp,
   input  logic [REG_W-1:0]    wb_reg,
   output logic                issue_valid,
   output logic [WID_W-1:0]    issue_warp,
   output logic [INSTR_W-1:0]  issue_instr
);
   localparam int LANE_CYCLES = wis_pkg::lane_cycles(WARP_THREADS, EXEC_LANES);
   localparam int LONG_BIT    = 3 * REG_W;

   if (NUM_WARPS < 2) begin : g_chk_warps
      $error("wis_issue_sched: NUM_WARPS must be at least 2");
   end
   if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_chk_regs
      $error("wis_issue_sched: NUM_REGS must be a power of two");
   end
   if (INSTR_W < LONG_BIT + 1) begin : g_chk_width
      $error("wis_issue_sched: INSTR_W too narrow for register fields");
   end

   logic [NUM_WARPS-1:0]                slot_valid;
   logic [NUM_WARPS-1:0][INSTR_W-1:0]   slot_instr;
   logic [NUM_WARPS-1:0][NUM_REGS-1:0]  pend;
   logic [NUM_WARPS-1:0]                elig;
   logic                                lanes_free;
   logic                                gnt_valid;
   logic [WID_W-1:0]                    gnt_idx;
   logic [WID_W-1:0]                    rr_ptr;
   logic [INSTR_W-1:0]                  gnt_instr;

   wis_instr_buf #(.NUM_WARPS(NUM_WARPS), .INSTR_W(INSTR_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_instr(fill_instr),
      .req_ready(fetch_req_ready), .req_valid(fetch_req_valid), .req_warp(fetch_req_warp),
      .take_en(gnt_valid), .take_warp(gnt_idx),
      .slot_valid(slot_valid), .slot_instr(slot_instr));

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_elig
      logic [REG_W-1:0] ra, rb, rd;
      assign ra = slot_instr[w][REG_W-1:0];
      assign rb = slot_instr[w][2*REG_W-1:REG_W];
      assign rd = slot_instr[w][3*REG_W-1:2*REG_W];
      assign elig[w] = slot_valid[w] & ~pend[w][ra] & ~pend[w][rb] & ~pend[w][rd];
   end

   wis_rr_arbiter #(.NUM_WARPS(NUM_WARPS)) u_arb (
      .clk(clk), .rst_n(rst_n),
      .req(elig & {NUM_WARPS{lanes_free}}), .start(rr_ptr),
      .gnt_valid(gnt_valid), .gnt_idx(gnt_idx));

   assign gnt_instr = slot_instr[gnt_idx];

   wis_scoreboard #(.NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS)) u_sb (
      .clk(clk), .rst_n(rst_n),
      .set_en(gnt_valid && gnt_instr[LONG_BIT]), .set_warp(gnt_idx),
      .set_reg(gnt_instr[3*REG_W-1:2*REG_W]),
      .clr_en(wb_valid), .clr_warp(wb_warp), .clr_reg(wb_reg),
      .pend(pend));

   // lane occupancy: variant chosen by how many cycles one warp needs
   if (LANE_CYCLES > 1) begin : g_occ
      localparam int OCC_W = $clog2(LANE_CYCLES);
      logic [OCC_W-1:0] busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               busy_q <= '0;
         else if (gnt_valid)       busy_q <= OCC_W'(LANE_CYCLES - 1);
         else if (busy_q != '0)    busy_q <= busy_q - 1'b1;
      end
      assign lanes_free = (busy_q == '0);
      // R6: the issue following a decision is followed by idle cycles
      assert_occupancy_R6: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid |-> !gnt_valid);
   end else begin : g_no_occ
      assign lanes_free = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr      <= '0;
         issue_valid <= 1'b0;
         issue_warp  <= '0;
         issue_instr <= '0;
      end else begin
         issue_valid <= gnt_valid;
         if (gnt_valid) begin
            issue_warp  <= gnt_idx;
            issue_instr <= gnt_instr;
            rr_ptr      <= (gnt_idx == WID_W'(NUM_WARPS - 1)) ? '0 : gnt_idx + 1'b1;
         end
      end
   end

   // R9: the issued word is the slot content at the decision
   assert_issue_payload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |=> issue_instr == $past(slot_instr[gnt_idx]) && !slot_valid[$past(gnt_idx)]);
   // R10: no decision, no issue and the pointer holds
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_valid |=> !issue_valid && $stable(rr_ptr));
   // R4/R5: an issued instruction had no pending operand or destination
   assert_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> !pend[gnt_idx][gnt_instr[REG_W-1:0]] &&
                    !pend[gnt_idx][gnt_instr[2*REG_W-1:REG_W]] &&
                    !pend[gnt_idx][gnt_instr[3*REG_W-1:2*REG_W]]);
endmodule

// File: tb/wis_issue_sched_test.sv
module wis_issue_sched_test;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 5;
   localparam int NR = 16;
   localparam int IW = 20;
   localparam int LC = 4;
   localparam int WW = $clog2(NW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fetch_req_ready = 1'b0;
   logic fill_valid = 1'b0;
   logic [WW-1:0] fill_warp = '0;
   logic [IW-1:0] fill_instr = '0;
   logic wb_valid = 1'b0;
   logic [WW-1:0] wb_warp = '0;
   logic [3:0] wb_reg = '0;
   logic fetch_req_valid, issue_valid;
   logic [WW-1:0] fetch_req_warp, issue_warp;
   logic [IW-1:0] issue_instr;

   always #(CLK_PERIOD/2) clk = ~clk;

   wis_issue_sched #(.NUM_WARPS(NW), .NUM_REGS(NR), .INSTR_W(IW)) uut (
      .clk(clk), .rst_n(rst_n),
      .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
      .fetch_req_warp(fetch_req_warp),
      .fill_valid(fill_valid), .fill_warp(fill_warp), .fill_instr(fill_instr),
      .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
      .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_instr(issue_instr));

   int checks = 0, errors = 0;
   // reference model state
   bit          m_sv [NW];
   logic [IW-1:0] m_si [NW];
   bit          m_rq [NW];
   bit [NR-1:0] m_sb [NW];
   int m_busy = 0, m_ptr = 0, m_iw = 0;
   bit m_iv = 0;
   logic [IW-1:0] m_ii = '0;
   int due [NW];
   int cyc = 0, last_issue = -100, n_issue = 0, n_ignored = 0, n_stale = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual %0h expected %0h", req, cyc, act, exp);
      end
   endtask

   function automatic int model_req();
      for (int w = 0; w < NW; w++) if (!m_sv[w] && !m_rq[w]) return w;
      return -1;
   endfunction

   function automatic bit model_ready(input int w);
      logic [IW-1:0] x;
      x = m_si[w];
      return !m_sb[w][x[3:0]] && !m_sb[w][x[7:4]] && !m_sb[w][x[11:8]];
   endfunction

   task automatic model_step(input bit rdy, input bit fv, input int fw,
                             input logic [IW-1:0] fi, input bit wv, input int ww, input int wr);
      bit sv0 [NW];
      int g, rc;
      sv0 = m_sv;
      rc = model_req();
      g = -1;
      if (m_busy == 0)
         for (int i = 0; i < NW; i++) begin
            int k;
            k = (m_ptr + i) % NW;
            if (g < 0 && sv0[k] && model_ready(k)) g = k;
         end
      m_iv = (g >= 0);
      if (wv) m_sb[ww][wr] = 1'b0;
      if (g >= 0) begin
         m_iw = g; m_ii = m_si[g]; m_sv[g] = 1'b0;
         m_busy = LC - 1; m_ptr = (g + 1) % NW;
         if (m_ii[12]) m_sb[g][m_ii[11:8]] = 1'b1;
      end else if (m_busy > 0) m_busy--;
      if (fv && !sv0[fw]) begin
         m_sv[fw] = 1'b1; m_si[fw] = fi; m_rq[fw] = 1'b0;
      end
      if (rc >= 0 && rdy) m_rq[rc] = 1'b1;
   endtask

   task automatic compare();
      int rc;
      rc = model_req();
      chk(fetch_req_valid == (rc >= 0), "R2 fetch_req_valid", fetch_req_valid, rc >= 0);
      if (rc >= 0) chk(fetch_req_warp == WW'(rc), "R2 fetch_req_warp", fetch_req_warp, rc);
      chk(issue_valid == m_iv, "R6/R10 issue_valid", issue_valid, m_iv);
      if (m_iv) begin
         chk(issue_warp == WW'(m_iw), "R7 issue_warp round-robin", issue_warp, m_iw);
         chk(issue_instr == m_ii, "R9/R3 issue_instr", issue_instr, m_ii);
      end
      if (issue_valid) begin
         chk(cyc - last_issue >= LC, "R6 lane occupancy spacing", cyc - last_issue, LC);
         last_issue = cyc; n_issue++;
      end
   endtask

   task automatic run_phase(input int ncyc, input int wb_pct);
      for (int c = 0; c < ncyc; c++) begin
         bit rdy, fv, wv;
         int fw, ww, wr, rc;
         logic [IW-1:0] fi;
         @(negedge clk);
         cyc++;
         compare();
         fv = 0; fw = 0; wv = 0; ww = 0; wr = 0;
         fi = IW'($urandom);
         for (int w = 0; w < NW; w++)
            if (due[w] == 0 && !fv) begin fv = 1; fw = w; due[w] = -1; end
         for (int w = 0; w < NW; w++) if (due[w] > 0) due[w]--;
         if (!fv && ($urandom % 6) == 0) begin
            int s;
            s = $urandom % NW;
            for (int i = 0; i < NW; i++)
               if (!fv && m_sv[(s + i) % NW]) begin
                  fv = 1; fw = (s + i) % NW; n_ignored++;  // R3 full-slot fill
               end
         end
         if (($urandom % 100) < wb_pct) begin
            int s, r0;
            s = $urandom % NW; r0 = $urandom % NR;
            for (int i = 0; i < NW * NR; i++) begin
               int w2, r2;
               w2 = (s + i / NR) % NW; r2 = (r0 + i) % NR;
               if (!wv && m_sb[w2][r2]) begin wv = 1; ww = w2; wr = r2; end
            end
         end else if (($urandom % 10) == 0) begin
            int w2, r2;
            w2 = $urandom % NW; r2 = $urandom % NR;
            if (!m_sb[w2][r2]) begin wv = 1; ww = w2; wr = r2; n_stale++; end  // R8 stale writeback
         end
         rdy = ($urandom % 4) != 0;
         rc = model_req();
         if (rc >= 0 && rdy) due[rc] = $urandom % 4;
         fetch_req_ready = rdy;
         fill_valid = fv; fill_warp = WW'(fw); fill_instr = fi;
         wb_valid = wv; wb_warp = WW'(ww); wb_reg = 4'(wr);
         model_step(rdy, fv, fw, fi, wv, ww, wr);
      end
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         m_sv[w] = 0; m_si[w] = '0; m_rq[w] = 0; m_sb[w] = '0; due[w] = -1;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!issue_valid, "R1 issue_valid after reset", issue_valid, 0);
      chk(fetch_req_valid && fetch_req_warp == '0, "R1 fetch request warp 0",
          {fetch_req_valid, fetch_req_warp}, {1'b1, WW'(0)});
      run_phase(3000, 60);   // R4 R5 R7 R8 frequent writebacks
      run_phase(3000, 8);    // R5 R7 R10 mostly stalled warps
      run_phase(1000, 90);
      chk(n_issue > 200, "R7 issue progress", n_issue, 200);
      chk(n_ignored > 20, "R3 full-slot fills exercised", n_ignored, 20);
      chk(n_stale > 5, "R8 stale writebacks exercised", n_stale, 5);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule